// File: doc/BRIEF.md
# Addressed Serial Control Receiver

This block receives control words from a three-wire serial link made of a chip-enable line, a serial clock and a serial data line, and keeps the last accepted word in a holding register. A host first clocks an 8-bit device address while chip-enable is low. It then raises chip-enable and clocks a 44-bit data word. When chip-enable drops, the block commits the word, but only if the address matched the fixed device code.

The three serial lines are brought into the system clock domain through a synchronizer. Edges are detected there, so the system clock must run at least eight times faster than the serial clock. A receive state machine has three states. `ST_ADDR` collects address bits while chip-enable is low. `ST_DATA` collects data bits after a matching address. `ST_SKIP` waits out the data phase of a frame meant for another device. The machine has four transitions:

- `ST_ADDR -> ST_DATA` on a chip-enable rise with a full, matching address.
- `ST_ADDR -> ST_SKIP` on a chip-enable rise otherwise.
- `ST_DATA -> ST_ADDR` on a chip-enable fall, which either commits the word or flags a short frame.
- `ST_SKIP -> ST_ADDR` on a chip-enable fall.

Hosts that can only send whole bytes may pad the data phase with leading filler bits. The receiver keeps the most recent 44 data bits, so the filler drops out.

Top module: `serctl_rx`

## Requirements
- R1: After reset, `payload` is all zeros and `frame_valid` and `short_err` are low.
- R2: Address bits are sampled on serial clock rises while chip-enable is low, least significant bit first. Only the last 8 bits before chip-enable rises count, and at least 8 must have arrived since the previous chip-enable fall. The device code is 0x81, which is sent as the bit sequence 1,0,0,0,0,0,0,1.
- R3: Data bits are sampled on serial clock rises while chip-enable is high. In a 44-bit data phase, the first bit received lands in `payload[0]` and the last bit lands in `payload[43]`.
- R4: When chip-enable falls after a matching address and at least 44 data bits, `payload` takes the captured word and `frame_valid` is high for exactly one system clock cycle, within a few system clock cycles of the fall.
- R5: When more than 44 data bits are sent, only the last 44 are kept. In a 48-bit data phase, the first 4 bits are discarded.
- R6: A frame whose address does not match changes nothing: `payload` keeps its value, and neither `frame_valid` nor `short_err` pulses.
- R7: A matching frame with fewer than 44 data bits pulses `short_err` for one cycle, gives no `frame_valid`, and leaves `payload` unchanged.
- R8: Serial clocking while chip-enable stays low, with no chip-enable rise, never changes `payload` and never pulses `frame_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data line |
| ser_en | input | 1 | Chip-enable: low for the address phase, high for the data phase |
| payload | output | 44 | Last committed data word; bit i is the i-th data bit received |
| frame_valid | output | 1 | One-cycle strobe when a new word is committed |
| short_err | output | 1 | One-cycle strobe when a matching frame ended with fewer than 44 data bits |

## Verification
The bench builds the block with its default parameters: 8 address bits, 44 data bits, device code 0x81 and two synchronizer stages. It drives the serial clock at one sixteenth of the system clock rate. Data phase lengths of 43, 44, 48 and 52 bits cover the short-frame, exact, byte-padded and heavily padded cases. Address patterns cover a match, near misses in the first and the last address bit, extra leading address bits, and a 7-bit address.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
    typedef enum logic [1:0] {
        ST_ADDR = 2'd0,
        ST_DATA = 2'd1,
        ST_SKIP = 2'd2
    } rx_state_e;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/serctl_shreg.sv
module serctl_shreg #(
    parameter int W = 44
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q,
    output logic         full
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            cnt <= '0;
        end else if (clr) begin
            q   <= '0;
            cnt <= '0;
        end else if (shift) begin
            q <= {din, q[W-1:1]};
            if (cnt != CW'(W)) cnt <= cnt + 1'b1;
        end
    end

    assign full = (cnt == CW'(W));
endmodule

// File: rtl/serctl_rx.sv
module serctl_rx
    import serctl_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 44,
    parameter int unsigned DEV_CODE    = 32'h81,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_en,
    output logic [DATA_W-1:0] payload,
    output logic              frame_valid,
    output logic              short_err
);
    localparam logic [ADDR_W-1:0] CODE = ADDR_W'(DEV_CODE);

    logic [2:0] s_lines;
    logic [1:0] ctl_d;
    logic       sck_rise, en_rise, en_fall;

    rx_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic              addr_full;
    logic [DATA_W-1:0] data_q;
    logic              data_full;
    logic              addr_ok;

    serctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_en, ser_dat, ser_clk}),
        .dout (s_lines)
    );

    // delayed copies of the synchronized serial clock and chip-enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_d <= '0;
        else        ctl_d <= {s_lines[2], s_lines[0]};
    end

    assign sck_rise = s_lines[0] & ~ctl_d[0];
    assign en_rise  = s_lines[2] & ~ctl_d[1];
    assign en_fall  = ~s_lines[2] & ctl_d[1];

    serctl_shreg #(.W(ADDR_W)) u_addr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (en_fall),
        .shift(state_q == ST_ADDR && sck_rise && !s_lines[2]),
        .din  (s_lines[1]),
        .q    (addr_q),
        .full (addr_full)
    );

    serctl_shreg #(.W(DATA_W)) u_data (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (en_rise),
        .shift(state_q == ST_DATA && sck_rise),
        .din  (s_lines[1]),
        .q    (data_q),
        .full (data_full)
    );

    assign addr_ok = addr_full && (addr_q == CODE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ADDR;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ADDR: if (en_rise) state_d = addr_ok ? ST_DATA : ST_SKIP;
            ST_DATA: if (en_fall) state_d = ST_ADDR;
            ST_SKIP: if (en_fall) state_d = ST_ADDR;
            default: state_d = ST_ADDR;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            payload     <= '0;
            frame_valid <= 1'b0;
            short_err   <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            short_err   <= 1'b0;
            if (state_q == ST_DATA && en_fall) begin
                if (data_full) begin
                    payload     <= data_q;
                    frame_valid <= 1'b1;
                end else begin
                    short_err <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/serctl_rx_chk.sv
module serctl_rx_chk #(
    parameter int DATA_W = 44
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_en,
    input logic [DATA_W-1:0] payload,
    input logic              frame_valid,
    input logic              short_err
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (payload == '0 && !frame_valid && !short_err)) else $error("reset state"); // R1
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) frame_valid |=> !frame_valid) else $error("valid width"); // R4
    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) frame_valid |-> !ser_en) else $error("valid while enabled"); // R4
    AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n) !frame_valid |-> $stable(payload)) else $error("payload moved"); // R6
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) short_err |=> !short_err) else $error("err width"); // R7
    AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n) !(short_err && frame_valid)) else $error("err with valid"); // R7
endmodule

bind serctl_rx serctl_rx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/serctl_rx_test.sv
module serctl_rx_test;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_en = 1'b0;
    logic [43:0] payload;
    logic        frame_valid;
    logic        short_err;

    int n_tests = 0;
    int n_fail  = 0;
    int n_valid = 0;
    int n_err   = 0;
    bit done    = 1'b0;
    logic [43:0] model = '0;

    always #10 clk = ~clk;

    serctl_rx uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_en(ser_en), .payload(payload), .frame_valid(frame_valid),
        .short_err(short_err)
    );

    always @(negedge clk) begin
        if (frame_valid) n_valid++;
        if (short_err)   n_err++;
    end

    // {address, data bit count, data bits sent LSB first}
    localparam logic [79:0] VEC [8] = '{
        {8'h81, 8'd44, 64'h0000_0ABC_DEF0_1234},
        {8'h81, 8'd48, 64'h0000_C3A5_9617_E28D},
        {8'h80, 8'd44, 64'h0000_0111_2222_3333},
        {8'h81, 8'd43, 64'h0000_0555_6666_7777},
        {8'h81, 8'd44, 64'h0000_0FFF_FFFF_FFFF},
        {8'h01, 8'd44, 64'h0000_0999_8888_7777},
        {8'h81, 8'd52, 64'h000F_EDCB_A987_6543},
        {8'h81, 8'd44, 64'h0000_0000_0000_0000}
    };

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        wait_cyc(HALF);
        ser_clk = 1'b1;
        wait_cyc(HALF);
        ser_clk = 1'b0;
    endtask

    task automatic run_frame(input logic [15:0] abits, input int na,
                             input logic [63:0] d, input int nd);
        for (int i = 0; i < na; i++) send_bit(abits[i]);
        wait_cyc(HALF);
        ser_en = 1'b1;
        wait_cyc(HALF);
        for (int i = 0; i < nd; i++) send_bit(d[i]);
        wait_cyc(HALF);
        ser_en = 1'b0;
        wait_cyc(20);
    endtask

    task automatic frame_check(input logic [15:0] abits, input int na,
                               input logic [63:0] d, input int nd,
                               input bit exp_v, input bit exp_e, input string tag);
        int v0, e0;
        v0 = n_valid;
        e0 = n_err;
        run_frame(abits, na, d, nd);
        if (exp_v) model = 44'(d >> (nd - 44));
        check(n_valid - v0 == int'(exp_v), tag, "valid pulses", 64'(n_valid - v0), 64'(exp_v));
        check(n_err - e0 == int'(exp_e), tag, "error pulses", 64'(n_err - e0), 64'(exp_e));
        check(payload == model, tag, "payload", 64'(payload), 64'(model));
    endtask

    initial begin
        wait_cyc(5);
        // R1: reset state
        check(payload == '0, "R1", "payload after reset", 64'(payload), 64'h0);
        check(!frame_valid && !short_err, "R1", "strobes after reset",
              {62'h0, frame_valid, short_err}, 64'h0);
        rst_n = 1'b1;
        wait_cyc(5);

        foreach (VEC[k]) begin
            logic [7:0]  a;
            int          nd;
            logic [63:0] d;
            bit          hit;
            string       tag;
            a   = VEC[k][79:72];
            nd  = int'(VEC[k][71:64]);
            d   = VEC[k][63:0];
            hit = (a == 8'h81);
            if (!hit)          tag = "R6";
            else if (nd < 44)  tag = "R7";
            else if (nd > 44)  tag = "R5";
            else               tag = "R3";
            frame_check({8'h00, a}, 8, d, nd, hit && nd >= 44, hit && nd < 44, tag);
        end

        // R8: address clocking with no enable rise
        begin
            int v0;
            v0 = n_valid;
            for (int i = 0; i < 8; i++) send_bit(i == 0 || i == 7);
            for (int i = 0; i < 20; i++) send_bit(1'b1);
            wait_cyc(30);
            check(n_valid == v0, "R8", "valid without enable", 64'(n_valid - v0), 64'h0);
            check(payload == model, "R8", "payload without enable", 64'(payload), 64'(model));
        end

        // R2: extra leading address bits, last eight match
        frame_check({3'b0, 5'b00000, 8'h81} << 0 | 16'h0000, 8, 64'h0000_0123_4567_89AB, 44, 1'b1, 1'b0, "R2");
        frame_check({5'b0, 8'h81, 3'b110}, 11, 64'h0000_0FED_CBA9_8765, 44, 1'b1, 1'b0, "R2");
        // R2: only seven address bits
        frame_check({9'b0, 7'b1000000}, 7, 64'h0000_0AAA_BBBB_CCCC, 44, 1'b0, 1'b0, "R2");
        // R4: back-to-back frames commit each time
        frame_check({8'h00, 8'h81}, 8, 64'h0000_0800_0000_0001, 44, 1'b1, 1'b0, "R4");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule